// File: doc/BRIEF.md
# UART channel-mode router and control decoder

This block sits between a UART's serial shifters and its two character FIFOs. It holds the control and mode settings written by software, turns them into direction enables, a break request, a receive-timeout restart pulse, one-cycle FIFO flush pulses and the word-format fields the shifters need. It also steers every character to the right FIFO for the selected channel mode.

Characters arrive from the serial receiver with a valid/ready handshake and from the host through a one-cycle write strobe. Depending on the channel mode, a received character is pushed into the receive FIFO, the transmit FIFO, both (automatic echo) or neither (local loopback, where the shifters are tied together outside this block). A host write goes to the transmit FIFO, or to the receive FIFO in local loopback. Readiness toward the receiver is computed from the free space of every FIFO the character would reach, and a push still in flight is taken into account. All push strobes and event outputs are registered.

Top module: `uart_mode_router`

## Requirements
- R1: A control write (address 0) with bit 0 set drives `rxf_reset` high for exactly one cycle, starting the cycle after the write. Bit 1 does the same for `txf_reset`. Neither bit is retained, so a later control write without it gives no pulse.
- R2: The receive direction is active (`rx_en`=1) only when control bit 2 is 1 and bit 3 is 0. The transmit direction is active (`tx_en`=1) only when bit 4 is 1 and bit 5 is 0.
- R3: `brk_req` is 1 when control bit 7 is 1 and bit 8 is 0. A control write with bit 6 set gives a one-cycle `tmo_restart` pulse.
- R4: Bits 9:8 of the mode register (address 1) set `chan_mode`: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. The value holds until the next mode write.
- R5: An accepted received character is pushed one cycle later, carrying its data. In normal mode it goes to the receive FIFO, in echo mode to both FIFOs, in remote loopback to the transmit FIFO only, and in local loopback to neither.
- R6: `rx_char_ready` is 1 only when every destination FIFO of the current mode has room, after subtracting a push issued in the previous cycle. It is 0 in any cycle where `host_wr` is 1.
- R7: A host write goes to the transmit FIFO in normal and echo modes and to the receive FIFO in local loopback. It is ignored in remote loopback.
- R8: Mode bits 2:1 give `fmt_nbits`: 3 gives 6, 2 gives 7, otherwise 8. Bits 5:3 give parity: 0 even, 1 odd, any other value none (`fmt_par_en`=0). Bits 7:6 equal to 2 select two stop bits, otherwise one.
- R9: After reset the control value is 0x128: both directions are inactive, there is no break, and no pulses are present. The mode value is 0: normal mode, 8 bits, even parity, one stop bit.
- R10: A host write whose target FIFO has no room is dropped and gives a one-cycle `ovr_evt`. A received character reaching a FIFO whose direction is inactive is consumed without a push to that FIFO.
- R11: A control write that flushes a FIFO suppresses any push to that FIFO that would otherwise be issued by the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 mode |
| reg_wdata | input | REG_W | Register write value |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | DW | Host data character |
| rx_char_valid | input | 1 | Received character valid |
| rx_char_data | input | DW | Received character |
| rx_char_ready | output | 1 | Router can take the received character |
| rxf_space | input | SPC_W | Free entries in the receive FIFO |
| txf_space | input | SPC_W | Free entries in the transmit FIFO |
| rxf_push | output | 1 | Push strobe to the receive FIFO |
| rxf_push_data | output | DW | Character for the receive FIFO |
| txf_push | output | 1 | Push strobe to the transmit FIFO |
| txf_push_data | output | DW | Character for the transmit FIFO |
| rxf_reset | output | 1 | One-cycle receive FIFO flush |
| txf_reset | output | 1 | One-cycle transmit FIFO flush |
| ovr_evt | output | 1 | One-cycle overflow event from a dropped host write |
| rx_en | output | 1 | Receive direction active |
| tx_en | output | 1 | Transmit direction active |
| brk_req | output | 1 | Break request to the transmitter |
| tmo_restart | output | 1 | One-cycle receive-timeout restart |
| chan_mode | output | 2 | Current channel mode |
| fmt_nbits | output | 4 | Data bits per character (6, 7 or 8) |
| fmt_par_en | output | 1 | Parity enabled |
| fmt_par_odd | output | 1 | Odd parity when enabled |
| fmt_two_stop | output | 1 | Two stop bits |

## Verification
The bench goes after the cases that are easy to get wrong. The first is a FIFO with one free slot: a router that ignores its own in-flight push would raise ready again and overfill the FIFO. The second is echo mode: a router that picks one destination would miss a push on one side. The third is host writes in local and remote loopback: a wrong route would push to the transmit FIFO, or drop a character that should land in the receive FIFO. It also checks that the flush bits are not retained, that a flush in the same cycle as an arriving character stops its push, and that a host write to a full FIFO is dropped with an overflow event and no stray push.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  // control register bit positions
  localparam int unsigned B_RXRST   = 0;
  localparam int unsigned B_TXRST   = 1;
  localparam int unsigned B_RXEN    = 2;
  localparam int unsigned B_RXDIS   = 3;
  localparam int unsigned B_TXEN    = 4;
  localparam int unsigned B_TXDIS   = 5;
  localparam int unsigned B_TMO     = 6;
  localparam int unsigned B_BRKGO   = 7;
  localparam int unsigned B_BRKSTOP = 8;

  // mode register field positions
  localparam int unsigned M_LEN_LO  = 1;
  localparam int unsigned M_PAR_LO  = 3;
  localparam int unsigned M_STOP_LO = 6;
  localparam int unsigned M_CH_LO   = 8;

  localparam logic [15:0] CTRL_RESET = 16'h0128;

  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned MODE_ADDR = 1;
endpackage

// File: rtl/uart_ctl_decode.sv
module uart_ctl_decode
  import uart_route_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brk_req,
  output logic              tmo_restart,
  output logic              rxf_reset,
  output logic              txf_reset,
  output logic              rx_flush_req,
  output logic              tx_flush_req
);
  localparam logic RX_EN_RST = CTRL_RESET[B_RXEN] & ~CTRL_RESET[B_RXDIS];
  localparam logic TX_EN_RST = CTRL_RESET[B_TXEN] & ~CTRL_RESET[B_TXDIS];
  localparam logic BRK_RST   = CTRL_RESET[B_BRKGO] & ~CTRL_RESET[B_BRKSTOP];

  logic ctl_wr;
  logic unused_hi;

  assign ctl_wr       = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign rx_flush_req = ctl_wr && reg_wdata[B_RXRST];
  assign tx_flush_req = ctl_wr && reg_wdata[B_TXRST];
  assign unused_hi    = ^reg_wdata[REG_W-1:B_BRKSTOP+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en       <= RX_EN_RST;
      tx_en       <= TX_EN_RST;
      brk_req     <= BRK_RST;
      tmo_restart <= 1'b0;
      rxf_reset   <= 1'b0;
      txf_reset   <= 1'b0;
    end else begin
      // flush and restart bits act once and are never held
      rxf_reset   <= rx_flush_req;
      txf_reset   <= tx_flush_req;
      tmo_restart <= ctl_wr && reg_wdata[B_TMO];
      if (ctl_wr) begin
        rx_en   <= reg_wdata[B_RXEN] & ~reg_wdata[B_RXDIS];
        tx_en   <= reg_wdata[B_TXEN] & ~reg_wdata[B_TXDIS];
        brk_req <= reg_wdata[B_BRKGO] & ~reg_wdata[B_BRKSTOP];
      end
    end
  end

  // R1: a flush pulse lasts one cycle unless re-requested
  p_rx_flush_once_r1: assert property (@(posedge clk) disable iff (rst)
    (rxf_reset && !rx_flush_req) |=> !rxf_reset);
  p_tx_flush_once_r1: assert property (@(posedge clk) disable iff (rst)
    (txf_reset && !tx_flush_req) |=> !txf_reset);
  // R3: break only starts after a control write
  p_brk_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_req) |-> $past(ctl_wr));
  // R2: enables change only on a control write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(rx_en) && $stable(tx_en)));
endmodule

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
  import uart_route_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output chan_mode_e        chan_mode,
  output logic [3:0]        fmt_nbits,
  output logic              fmt_par_en,
  output logic              fmt_par_odd,
  output logic              fmt_two_stop
);
  logic       mode_wr;
  logic [1:0] len_f;
  logic [2:0] par_f;
  logic [1:0] stop_f;
  logic       unused_bits;

  assign mode_wr     = reg_we && (reg_addr == ADDR_W'(MODE_ADDR));
  assign len_f       = reg_wdata[M_LEN_LO +: 2];
  assign par_f       = reg_wdata[M_PAR_LO +: 3];
  assign stop_f      = reg_wdata[M_STOP_LO +: 2];
  assign unused_bits = reg_wdata[0] ^ (^reg_wdata[REG_W-1:M_CH_LO+2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_mode    <= CH_NORMAL;
      fmt_nbits    <= 4'd8;
      fmt_par_en   <= 1'b1;
      fmt_par_odd  <= 1'b0;
      fmt_two_stop <= 1'b0;
    end else if (mode_wr) begin
      chan_mode <= chan_mode_e'(reg_wdata[M_CH_LO +: 2]);
      case (len_f)
        2'd3:    fmt_nbits <= 4'd6;
        2'd2:    fmt_nbits <= 4'd7;
        default: fmt_nbits <= 4'd8;
      endcase
      fmt_par_en   <= (par_f == 3'd0) || (par_f == 3'd1);
      fmt_par_odd  <= (par_f == 3'd1);
      fmt_two_stop <= (stop_f == 2'd2);
    end
  end

  // R8: data length is always one of the three legal sizes
  p_nbits_legal_r8: assert property (@(posedge clk) disable iff (rst)
    (fmt_nbits >= 4'd6) && (fmt_nbits <= 4'd8));
  // R8: odd parity is only reported with parity enabled
  p_odd_needs_par_r8: assert property (@(posedge clk) disable iff (rst)
    fmt_par_odd |-> fmt_par_en);
  // R4: mode holds without a mode write
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(chan_mode));
endmodule

// File: rtl/uart_char_steer.sv
module uart_char_steer
  import uart_route_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SPC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_mode_e       mode_i,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_flush_req,
  input  logic             tx_flush_req,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             rx_char_valid,
  input  logic [DW-1:0]    rx_char_data,
  output logic             rx_char_ready,
  input  logic [SPC_W-1:0] rxf_space,
  input  logic [SPC_W-1:0] txf_space,
  output logic             rxf_push,
  output logic [DW-1:0]    rxf_push_data,
  output logic             txf_push,
  output logic [DW-1:0]    txf_push_data,
  output logic             ovr_evt
);
  logic          dst_rx, dst_tx;
  logic          rx_room, tx_room;
  logic          accept, h_rx, h_tx;
  logic          rx_push_n, tx_push_n, ovr_n;
  logic [DW-1:0] push_data_n;

  // room after the push that is still on its way into each FIFO
  assign rx_room = rxf_space > {{(SPC_W-1){1'b0}}, rxf_push};
  assign tx_room = txf_space > {{(SPC_W-1){1'b0}}, txf_push};

  assign dst_rx = (mode_i == CH_NORMAL) || (mode_i == CH_ECHO);
  assign dst_tx = (mode_i == CH_REMOTE) || (mode_i == CH_ECHO);

  assign rx_char_ready = !host_wr && (!dst_rx || rx_room) && (!dst_tx || tx_room);
  assign accept        = rx_char_valid && rx_char_ready;

  assign h_rx = host_wr && (mode_i == CH_LOCAL) && rx_en;
  assign h_tx = host_wr && ((mode_i == CH_NORMAL) || (mode_i == CH_ECHO)) && tx_en;

  assign push_data_n = host_wr ? host_wdata : rx_char_data;
  assign rx_push_n   = ((accept && dst_rx && rx_en) || (h_rx && rx_room)) && !rx_flush_req;
  assign tx_push_n   = ((accept && dst_tx && tx_en) || (h_tx && tx_room)) && !tx_flush_req;
  assign ovr_n       = (h_rx && !rx_room) || (h_tx && !tx_room);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_push      <= 1'b0;
      txf_push      <= 1'b0;
      ovr_evt       <= 1'b0;
      rxf_push_data <= '0;
      txf_push_data <= '0;
    end else begin
      rxf_push <= rx_push_n;
      txf_push <= tx_push_n;
      ovr_evt  <= ovr_n;
      if (rx_push_n) rxf_push_data <= push_data_n;
      if (tx_push_n) txf_push_data <= push_data_n;
    end
  end

  // R5: echo mode with both directions active feeds both FIFOs
  p_echo_both_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_char_valid && rx_char_ready && mode_i == CH_ECHO && rx_en && tx_en
     && !rx_flush_req && !tx_flush_req) |=> (rxf_push && txf_push));
  // R10: a dropped host write never comes with a push
  p_ovr_no_push_r10: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |-> (!rxf_push && !txf_push));
  // R6: the last free slot is not offered twice
  p_last_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (rxf_push && rxf_space == SPC_W'(1) && dst_rx) |-> !rx_char_ready);
  // R7: host write in local loopback lands in the receive FIFO only
  p_local_host_r7: assert property (@(posedge clk) disable iff (rst)
    (host_wr && mode_i == CH_LOCAL && rx_en && rxf_space >= SPC_W'(2) && !rx_flush_req)
    |=> (rxf_push && !txf_push));
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import uart_route_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2,
  localparam int SPC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              rx_char_valid,
  input  logic [DW-1:0]     rx_char_data,
  output logic              rx_char_ready,
  input  logic [SPC_W-1:0]  rxf_space,
  input  logic [SPC_W-1:0]  txf_space,
  output logic              rxf_push,
  output logic [DW-1:0]     rxf_push_data,
  output logic              txf_push,
  output logic [DW-1:0]     txf_push_data,
  output logic              rxf_reset,
  output logic              txf_reset,
  output logic              ovr_evt,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brk_req,
  output logic              tmo_restart,
  output logic [1:0]        chan_mode,
  output logic [3:0]        fmt_nbits,
  output logic              fmt_par_en,
  output logic              fmt_par_odd,
  output logic              fmt_two_stop
);
  chan_mode_e mode_w;
  logic       rx_flush_w, tx_flush_w;

  assign chan_mode = mode_w;

  uart_ctl_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata,
    .rx_en, .tx_en, .brk_req, .tmo_restart, .rxf_reset, .txf_reset,
    .rx_flush_req(rx_flush_w), .tx_flush_req(tx_flush_w)
  );

  uart_fmt_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_fmt (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata,
    .chan_mode(mode_w), .fmt_nbits, .fmt_par_en, .fmt_par_odd, .fmt_two_stop
  );

  uart_char_steer #(.DW(DW), .SPC_W(SPC_W)) u_steer (
    .clk, .rst, .mode_i(mode_w), .rx_en, .tx_en,
    .rx_flush_req(rx_flush_w), .tx_flush_req(tx_flush_w),
    .host_wr, .host_wdata, .rx_char_valid, .rx_char_data, .rx_char_ready,
    .rxf_space, .txf_space, .rxf_push, .rxf_push_data, .txf_push, .txf_push_data,
    .ovr_evt
  );
endmodule

// File: tb/uart_mode_router_bench.sv
module uart_mode_router_bench;
  localparam int DW = 8, DEPTH = 16, REG_W = 16, ADDR_W = 2;
  localparam int SPC_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic reg_we, host_wr, rx_char_valid;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0]  reg_wdata;
  logic [DW-1:0]     host_wdata, rx_char_data;
  logic [SPC_W-1:0]  rxf_space, txf_space;
  logic rx_char_ready, rxf_push, txf_push, rxf_reset, txf_reset, ovr_evt;
  logic rx_en, tx_en, brk_req, tmo_restart, fmt_par_en, fmt_par_odd, fmt_two_stop;
  logic [DW-1:0] rxf_push_data, txf_push_data;
  logic [1:0] chan_mode;
  logic [3:0] fmt_nbits;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_rx[$];
  logic [DW-1:0] exp_tx[$];

  always #10 clk = ~clk;

  uart_mode_router #(.DW(DW), .DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_uart_mode_router (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .host_wr, .host_wdata,
    .rx_char_valid, .rx_char_data, .rx_char_ready, .rxf_space, .txf_space,
    .rxf_push, .rxf_push_data, .txf_push, .txf_push_data, .rxf_reset, .txf_reset,
    .ovr_evt, .rx_en, .tx_en, .brk_req, .tmo_restart, .chan_mode, .fmt_nbits,
    .fmt_par_en, .fmt_par_odd, .fmt_two_stop
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: compare every push against the scoreboard queues
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rxf_push) begin
        if (exp_rx.size() == 0) check(1'b0, "R5 unexpected rx push", rxf_push_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rx.pop_front();
          check(rxf_push_data == e, "R5 rx push data", rxf_push_data, e);
        end
      end
      if (txf_push) begin
        if (exp_tx.size() == 0) check(1'b0, "R5 unexpected tx push", txf_push_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_tx.pop_front();
          check(txf_push_data == e, "R5 tx push data", txf_push_data, e);
        end
      end
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = REG_W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_char(input logic [DW-1:0] d);
    @(negedge clk);
    rx_char_valid = 1'b1; rx_char_data = d;
    @(negedge clk);
    rx_char_valid = 1'b0;
  endtask

  task automatic host_put(input logic [DW-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic drained(input string req);
    repeat (2) @(negedge clk);
    check(exp_rx.size() == 0 && exp_tx.size() == 0, req, exp_rx.size() + exp_tx.size(), 0);
    exp_rx.delete();
    exp_tx.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    host_wr = 1'b0; host_wdata = '0; rx_char_valid = 1'b0; rx_char_data = '0;
    rxf_space = SPC_W'(4); txf_space = SPC_W'(4);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check(!rx_en && !tx_en, "R9 directions off", {rx_en, tx_en}, 0);
    check(!brk_req && !rxf_reset && !txf_reset && !tmo_restart, "R9 no break or pulse",
          {brk_req, rxf_reset, txf_reset, tmo_restart}, 0);
    check(chan_mode == 2'd0 && fmt_nbits == 4'd8, "R9 mode normal 8 bits", {chan_mode, fmt_nbits}, 8);
    check(fmt_par_en && !fmt_par_odd && !fmt_two_stop, "R9 even parity one stop",
          {fmt_par_en, fmt_par_odd, fmt_two_stop}, 4);

    // R2 direction enables
    wr_reg(0, 'h14);
    check(rx_en && tx_en, "R2 both enabled", {rx_en, tx_en}, 3);
    wr_reg(0, 'h1C);
    check(!rx_en && tx_en, "R2 rx disable wins", {rx_en, tx_en}, 1);
    wr_reg(0, 'h34);
    check(rx_en && !tx_en, "R2 tx disable wins", {rx_en, tx_en}, 2);

    // R3 break and timeout restart
    wr_reg(0, 'h94);
    check(brk_req, "R3 break start", brk_req, 1);
    wr_reg(0, 'h194);
    check(!brk_req, "R3 stop break wins", brk_req, 0);
    wr_reg(0, 'h54);
    check(tmo_restart, "R3 timeout restart pulse", tmo_restart, 1);
    @(negedge clk);
    check(!tmo_restart, "R3 timeout restart ends", tmo_restart, 0);

    // R1 flush pulses
    wr_reg(0, 'h15);
    check(rxf_reset && !txf_reset, "R1 rx flush pulse", {rxf_reset, txf_reset}, 2);
    @(negedge clk);
    check(!rxf_reset, "R1 rx flush one cycle", rxf_reset, 0);
    wr_reg(0, 'h16);
    check(txf_reset && !rxf_reset, "R1 tx flush pulse", {rxf_reset, txf_reset}, 1);
    @(negedge clk);
    check(!txf_reset, "R1 tx flush one cycle", txf_reset, 0);
    wr_reg(0, 'h14);
    check(!rxf_reset && !txf_reset && rx_en && tx_en, "R1 flush bits not retained",
          {rxf_reset, txf_reset, rx_en, tx_en}, 3);

    // R4 R5 routing of received characters
    exp_rx.push_back(8'h41);
    send_char(8'h41);
    drained("R5 normal mode to rx fifo");
    wr_reg(1, 'h100);
    check(chan_mode == 2'd1, "R4 echo mode", chan_mode, 1);
    exp_rx.push_back(8'h42); exp_tx.push_back(8'h42);
    send_char(8'h42);
    drained("R5 echo mode to both fifos");
    wr_reg(1, 'h300);
    check(chan_mode == 2'd3, "R4 remote loopback", chan_mode, 3);
    exp_tx.push_back(8'h43);
    send_char(8'h43);
    drained("R5 remote loopback to tx fifo");
    wr_reg(1, 'h200);
    check(chan_mode == 2'd2, "R4 local loopback", chan_mode, 2);
    rxf_space = '0; txf_space = '0;
    #1;
    check(rx_char_ready, "R6 local loopback needs no room", rx_char_ready, 1);
    send_char(8'h44);
    drained("R5 local loopback drops received char");
    rxf_space = SPC_W'(4); txf_space = SPC_W'(4);

    // R7 host writes
    exp_rx.push_back(8'h51);
    host_put(8'h51);
    drained("R7 local host write to rx fifo");
    wr_reg(1, 'h000);
    exp_tx.push_back(8'h52);
    host_put(8'h52);
    drained("R7 normal host write to tx fifo");
    wr_reg(1, 'h100);
    exp_tx.push_back(8'h53);
    host_put(8'h53);
    drained("R7 echo host write to tx fifo");
    wr_reg(1, 'h300);
    host_put(8'h54);
    drained("R7 remote host write ignored");

    // R6 readiness
    wr_reg(1, 'h000);
    @(negedge clk);
    rxf_space = SPC_W'(1);
    #1;
    check(rx_char_ready, "R6 ready with one slot", rx_char_ready, 1);
    exp_rx.push_back(8'h61);
    rx_char_valid = 1'b1; rx_char_data = 8'h61;
    @(negedge clk);
    rx_char_valid = 1'b0;
    #1;
    check(!rx_char_ready, "R6 in-flight push takes last slot", rx_char_ready, 0);
    rxf_space = '0;
    #1;
    check(!rx_char_ready, "R6 full rx fifo", rx_char_ready, 0);
    drained("R6 single push into last slot");
    rxf_space = SPC_W'(4);
    wr_reg(1, 'h100);
    txf_space = '0;
    #1;
    check(!rx_char_ready, "R6 echo blocked by full tx fifo", rx_char_ready, 0);
    txf_space = SPC_W'(4);
    host_wr = 1'b1; host_wdata = 8'h00;
    #1;
    check(!rx_char_ready, "R6 host write blocks receiver", rx_char_ready, 0);
    exp_tx.push_back(8'h00);
    @(negedge clk);
    host_wr = 1'b0;
    drained("R6 host write during block");

    // R10 overflow and disabled direction
    wr_reg(1, 'h200);
    rxf_space = '0;
    host_put(8'h71);
    check(ovr_evt, "R10 overflow event", ovr_evt, 1);
    @(negedge clk);
    check(!ovr_evt, "R10 overflow one cycle", ovr_evt, 0);
    drained("R10 overflowed write dropped");
    rxf_space = SPC_W'(4);
    wr_reg(1, 'h000);
    wr_reg(0, 'h1C);
    send_char(8'h72);
    drained("R10 disabled receiver drops char");
    wr_reg(0, 'h14);

    // R11 flush in the same cycle as a character
    @(negedge clk);
    reg_we = 1'b1; reg_addr = '0; reg_wdata = REG_W'('h15);
    rx_char_valid = 1'b1; rx_char_data = 8'h77;
    @(negedge clk);
    reg_we = 1'b0; rx_char_valid = 1'b0;
    check(rxf_reset && !rxf_push, "R11 flush suppresses push", {rxf_reset, rxf_push}, 2);
    drained("R11 no push after flush");

    // R8 word format
    wr_reg(1, 'h06);
    check(fmt_nbits == 4'd6, "R8 six data bits", fmt_nbits, 6);
    wr_reg(1, 'h04);
    check(fmt_nbits == 4'd7, "R8 seven data bits", fmt_nbits, 7);
    wr_reg(1, 'h02);
    check(fmt_nbits == 4'd8, "R8 eight data bits", fmt_nbits, 8);
    wr_reg(1, 'h08);
    check(fmt_par_en && fmt_par_odd, "R8 odd parity", {fmt_par_en, fmt_par_odd}, 3);
    wr_reg(1, 'h10);
    check(!fmt_par_en, "R8 no parity", fmt_par_en, 0);
    wr_reg(1, 'h80);
    check(fmt_two_stop, "R8 two stop bits", fmt_two_stop, 1);
    wr_reg(1, 'hC0);
    check(!fmt_two_stop, "R8 one stop bit", fmt_two_stop, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule